// File: doc/BRIEF.md
# Shift-and-Add Reciprocal and Inverse Square Root Unit

This unit takes one normalised sign-magnitude floating-point operand and returns either its reciprocal or its reciprocal square root, chosen by a mode input. It computes by bisection. One result bit is settled per clock cycle. For each bit, the unit forms a trial value with that bit set and keeps the bit only if a residual cost stays non-negative. The cost is 1 − x·y in reciprocal mode and 1 − x·y² in inverse-square-root mode. No multiplier is used. The residual and its helper terms are updated with shifts, additions and one sign test.

A caller presents the operand and pulses `start` while the unit is idle. After a fixed number of cycles, `done` pulses for one cycle with the normalised mantissa, the exponent, the sign and an error flag. These outputs stay valid until the next `done`. A zero operand, or a negative operand in inverse-square-root mode, is rejected at once with the error flag and a zero result. One operation is in flight at a time.

Top module: `recip_rsqrt_unit`

## Requirements
- R1: After reset, `done`, `busy`, `res_err`, `res_sign`, `res_exp` and `res_man` are all zero.
- R2: Operand encoding:
  - `op_exp` is a two's-complement exponent e.
  - `op_man` is an MW-bit mantissa with bit MW-1 of weight 1, so m = op_man·2^-(MW-1) and the magnitude is m·2^e.
  - An operand whose bit MW-1 is 0 is treated as zero.
- R3: With `mode_rsqrt`=0, the result is the largest value on the result grid that does not exceed 1/|x|. The result value is res_man·2^-(RW-1)·2^res_exp, and `res_sign` equals `op_sign`.
- R4: With `mode_rsqrt`=1 and a positive operand, the result is the largest grid value that does not exceed 1/√x, and `res_sign` is 0.
- R5: In inverse-square-root mode, an odd exponent is handled by doubling the mantissa. The exponent part of the result then comes from floor(e/2).
- R6: A valid result is normalised: res_man bit RW-1 is 1. The exponent is −e (reciprocal) or −floor(e/2) (inverse square root) when the raw bisection value reaches 1.0, and one less otherwise.
- R7: A mantissa of exactly 1.0 gives res_man = 2^(RW-1) with no extra exponent decrement. This holds in reciprocal mode and in inverse-square-root mode with an even exponent.
- R8: A zero operand, or a negative operand with `mode_rsqrt`=1, gives `res_err`=1, `res_man`=0, `res_exp`=0 and `res_sign`=0. For such an operand, `done` rises at the same edge that accepts `start`.
- R9: For a valid operand, `busy` is high from the edge that accepts `start` until `done` is set. `done` is set at the (RW+2)-th rising edge after the accepting edge.
- R10: `done` lasts exactly one cycle, and the result outputs hold their values until the next `done`.
- R11: `start` has no effect while `busy` is high. Operand and mode changes at that time also have no effect: the running operation's result and latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one operation (sampled when idle) |
| mode_rsqrt | input | 1 | 0: reciprocal, 1: reciprocal square root |
| op_sign | input | 1 | Operand sign |
| op_exp | input | EW | Operand exponent, two's complement |
| op_man | input | MW | Operand mantissa, bit MW-1 has weight 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Operand rejected |
| res_sign | output | 1 | Result sign |
| res_exp | output | EW+1 | Result exponent, two's complement |
| res_man | output | RW | Result mantissa, bit RW-1 has weight 1 |

## Verification
Each wrong bit decision leaves the residual off by a power of two. Every later bit then inherits the error, so a fault shows up as a wrong `res_man` at the very next `done` of that operand. A bad exponent fold or normalisation choice shows up as an off-by-one `res_exp`. An error in the cycle counter moves `done` by whole cycles. The sweep covers every mantissa of a small configuration in both modes, over odd, even, extreme and negative exponents. Any such defect therefore appears at the port within one operation, about RW+3 cycles.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_NORM = 2'd2
  } rr_state_t;
endpackage

// File: rtl/rr_ctrl.sv
module rr_ctrl import rr_pkg::*; #(
  parameter int RW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_bad,
  output logic busy,
  output logic load,
  output logic step,
  output logic fin,
  output logic err_fin
);
  localparam int CNTW = $clog2(RW + 1) + 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(RW);

  rr_state_t st_q, st_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    err_fin = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (op_bad) begin
            err_fin = 1'b1;
          end else begin
            load  = 1'b1;
            cnt_n = '0;
            st_n  = ST_ITER;
          end
        end
      end
      ST_ITER: begin
        step = 1'b1;
        if (cnt_q == LAST) st_n = ST_NORM;
        else               cnt_n = cnt_q + 1'b1;
      end
      ST_NORM: begin
        fin  = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R9 / R11: busy only ever rises on an accepted start request
  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/rr_cost_path.sv
module rr_cost_path #(
  parameter int MW = 12,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          mode_rsqrt,
  input  logic          odd_exp,
  input  logic [MW-1:0] op_man,
  output logic [RW:0]   ybits
);
  localparam int FB = MW - 1 + 2 * RW;
  localparam int CW = FB + 5;
  localparam logic [CW-1:0] UNIT = {{(CW-1){1'b0}}, 1'b1} << FB;

  logic [CW-1:0] c_q, c_n, q_q, q_n, r_q, r_n;
  logic [RW:0]   y_q, y_n;
  logic          md_q, md_n;
  logic [CW-1:0] xin, delta, q_acc;
  logic [CW:0]   trial;
  logic          keep;

  always_comb begin
    xin = '0;
    xin[MW:0] = (mode_rsqrt && odd_exp) ? {op_man, 1'b0} : {1'b0, op_man};
    delta = q_q + r_q;
    trial = {1'b0, c_q} - {1'b0, delta};
    keep  = ~trial[CW];
    q_acc = keep ? (q_q + (r_q << 1)) : q_q;

    c_n  = c_q;
    q_n  = q_q;
    r_n  = r_q;
    y_n  = y_q;
    md_n = md_q;
    if (load) begin
      c_n  = UNIT;
      q_n  = '0;
      r_n  = xin << (2 * RW);
      y_n  = '0;
      md_n = mode_rsqrt;
    end else if (step) begin
      if (keep) c_n = trial[CW-1:0];
      y_n = {y_q[RW-1:0], keep};
      if (md_q) begin
        q_n = q_acc >> 1;
        r_n = r_q >> 2;
      end else begin
        q_n = '0;
        r_n = r_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q  <= '0;
      q_q  <= '0;
      r_q  <= '0;
      y_q  <= '0;
      md_q <= 1'b0;
    end else begin
      c_q  <= c_n;
      q_q  <= q_n;
      r_q  <= r_n;
      y_q  <= y_n;
      md_q <= md_n;
    end
  end

  assign ybits = y_q;

  // R3 / R4: the kept residual never exceeds one and never wraps negative
  assert_cost_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_q <= UNIT);
endmodule

// File: rtl/rr_result.sv
module rr_result #(
  parameter int RW = 12,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fin,
  input  logic          err_fin,
  input  logic          mode_rsqrt,
  input  logic          op_sign,
  input  logic [EW-1:0] op_exp,
  input  logic [RW:0]   ybits,
  output logic          done,
  output logic          res_err,
  output logic          res_sign,
  output logic [EW:0]   res_exp,
  output logic [RW-1:0] res_man
);
  logic signed [EW:0] e_ext, e_half, base_q, base_n;
  logic               sgn_q, sgn_n;
  logic               done_n, err_n, rs_n;
  logic [EW:0]        exp_n;
  logic [RW-1:0]      man_n;

  always_comb begin
    e_ext  = $signed({op_exp[EW-1], op_exp});
    e_half = e_ext >>> 1;
    base_n = base_q;
    sgn_n  = sgn_q;
    if (load) begin
      base_n = mode_rsqrt ? -e_half : -e_ext;
      sgn_n  = mode_rsqrt ? 1'b0 : op_sign;
    end

    done_n = fin | err_fin;
    err_n  = res_err;
    rs_n   = res_sign;
    exp_n  = res_exp;
    man_n  = res_man;
    if (err_fin) begin
      err_n = 1'b1;
      rs_n  = 1'b0;
      exp_n = '0;
      man_n = '0;
    end else if (fin) begin
      err_n = 1'b0;
      rs_n  = sgn_q;
      if (ybits[RW]) begin
        man_n = ybits[RW:1];
        exp_n = base_q;
      end else begin
        man_n = ybits[RW-1:0];
        exp_n = base_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      sgn_q    <= 1'b0;
      done     <= 1'b0;
      res_err  <= 1'b0;
      res_sign <= 1'b0;
      res_exp  <= '0;
      res_man  <= '0;
    end else begin
      base_q   <= base_n;
      sgn_q    <= sgn_n;
      done     <= done_n;
      res_err  <= err_n;
      res_sign <= rs_n;
      res_exp  <= exp_n;
      res_man  <= man_n;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_normalised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_err) |-> res_man[RW-1]);
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_err) |-> (res_man == '0 && res_exp == '0));
endmodule

// File: rtl/recip_rsqrt_unit.sv
module recip_rsqrt_unit #(
  parameter int MW = 12,
  parameter int RW = 12,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_rsqrt,
  input  logic          op_sign,
  input  logic [EW-1:0] op_exp,
  input  logic [MW-1:0] op_man,
  output logic          busy,
  output logic          done,
  output logic          res_err,
  output logic          res_sign,
  output logic [EW:0]   res_exp,
  output logic [RW-1:0] res_man
);
  logic          op_bad, load, step, fin, err_fin;
  logic [RW:0]   ybits;

  assign op_bad = ~op_man[MW-1] | (mode_rsqrt & op_sign);

  rr_ctrl #(.RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_bad(op_bad),
    .busy(busy), .load(load), .step(step), .fin(fin), .err_fin(err_fin)
  );

  rr_cost_path #(.MW(MW), .RW(RW)) u_cost (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mode_rsqrt(mode_rsqrt), .odd_exp(op_exp[0]), .op_man(op_man),
    .ybits(ybits)
  );

  rr_result #(.RW(RW), .EW(EW)) u_res (
    .clk(clk), .rst_n(rst_n), .load(load), .fin(fin), .err_fin(err_fin),
    .mode_rsqrt(mode_rsqrt), .op_sign(op_sign), .op_exp(op_exp),
    .ybits(ybits), .done(done), .res_err(res_err), .res_sign(res_sign),
    .res_exp(res_exp), .res_man(res_man)
  );
endmodule

// File: tb/tb_recip_rsqrt_unit.sv
module tb_recip_rsqrt_unit;
  localparam int MW = 8;
  localparam int RW = 8;
  localparam int EW = 6;

  logic          clk, rst_n, start, mode_rsqrt, op_sign;
  logic [EW-1:0] op_exp;
  logic [MW-1:0] op_man;
  logic          busy, done, res_err, res_sign;
  logic [EW:0]   res_exp;
  logic [RW-1:0] res_man;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat;

  recip_rsqrt_unit #(.MW(MW), .RW(RW), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rsqrt(mode_rsqrt),
    .op_sign(op_sign), .op_exp(op_exp), .op_man(op_man), .busy(busy),
    .done(done), .res_err(res_err), .res_sign(res_sign),
    .res_exp(res_exp), .res_man(res_man)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Arithmetic model of R3..R7
  task automatic model(input bit md, input bit sg, input int e, input int m,
                       output int eman, output int eexp, output bit esgn);
    longint y, mm, lim;
    int base;
    if (!md) begin
      y = (longint'(1) << (MW - 1 + RW)) / m;
      base = -e;
      esgn = sg;
    end else begin
      mm = ((e & 1) != 0) ? 2 * m : m;
      lim = longint'(1) << (MW - 1 + 2 * RW);
      y = longint'(1) << RW;
      while (mm * y * y > lim) y = y - 1;
      base = -(e >>> 1);
      esgn = 1'b0;
    end
    if (y == (longint'(1) << RW)) begin
      eman = 1 << (RW - 1);
      eexp = base;
    end else begin
      eman = int'(y);
      eexp = base - 1;
    end
  endtask

  // Drive one operation; optionally inject a start while busy (R11)
  task automatic run_op(input bit md, input bit sg, input int e, input int m, input bit inject);
    @(negedge clk);
    mode_rsqrt = md; op_sign = sg; op_exp = EW'(e); op_man = MW'(m); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin
      if (inject && lat == 3) begin
        start = 1'b1; mode_rsqrt = ~md; op_man = 8'hC3; op_exp = 6'd3; op_sign = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat = lat + 1;
    end
    start = 1'b0;
  endtask

  task automatic check_valid(input bit md, input bit sg, input int e, input int m, input bit inject);
    int eman, eexp;
    bit esgn;
    model(md, sg, e, m, eman, eexp, esgn);
    run_op(md, sg, e, m, inject);
    if (md) begin
      chk(res_man == RW'(eman), "R4/R5 rsqrt mantissa", res_man, eman);
      chk($signed(res_exp) == eexp, "R5/R6 rsqrt exponent", $signed(res_exp), eexp);
      chk(res_sign == esgn, "R4 rsqrt sign", res_sign, esgn);
    end else begin
      chk(res_man == RW'(eman), "R3 recip mantissa", res_man, eman);
      chk($signed(res_exp) == eexp, "R3/R6 recip exponent", $signed(res_exp), eexp);
      chk(res_sign == esgn, "R3 recip sign", res_sign, esgn);
    end
    chk(res_err == 1'b0, "R2 no error on valid operand", res_err, 0);
    chk(res_man[RW-1] == 1'b1, "R6 normalised mantissa", res_man[RW-1], 1);
    // done set at edge RW+2 after accept; seen at negedge number RW+3
    chk(lat == RW + 3, "R9 latency", lat, RW + 3);
  endtask

  task automatic check_err(input bit md, input bit sg, input int e, input int m);
    run_op(md, sg, e, m, 1'b0);
    chk(res_err == 1'b1, "R8 error flag", res_err, 1);
    chk(res_man == '0, "R8 zero mantissa", res_man, 0);
    chk(res_exp == '0, "R8 zero exponent", res_exp, 0);
    chk(res_sign == 1'b0, "R8 zero sign", res_sign, 0);
    chk(lat == 1, "R8 immediate done", lat, 1);
  endtask

  initial begin
    int ex [7] = '{-32, -7, -1, 0, 1, 6, 31};
    logic [RW-1:0] hold_man;
    logic [EW:0]   hold_exp;
    rst_n = 1'b0; start = 1'b0; mode_rsqrt = 1'b0; op_sign = 1'b0;
    op_exp = '0; op_man = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && busy == 1'b0, "R1 reset done/busy", {done, busy}, 0);
    chk(res_err == 1'b0 && res_sign == 1'b0, "R1 reset flags", {res_err, res_sign}, 0);
    chk(res_man == '0 && res_exp == '0, "R1 reset result", res_man, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 exact 1.0
    check_valid(1'b0, 1'b0, 4, 1 << (MW - 1), 1'b0);
    chk(res_man == RW'(1 << (RW - 1)) && $signed(res_exp) == -4, "R7 recip of 1.0", res_man, 1 << (RW - 1));
    check_valid(1'b1, 1'b0, 6, 1 << (MW - 1), 1'b0);
    chk(res_man == RW'(1 << (RW - 1)) && $signed(res_exp) == -3, "R7 rsqrt of 1.0", res_man, 1 << (RW - 1));

    // Sweep: all normalised mantissas, both modes, several exponents
    for (int md = 0; md < 2; md++)
      for (int k = 0; k < 7; k++)
        for (int m = 1 << (MW - 1); m < (1 << MW); m++)
          check_valid(md[0], (md == 0) ? m[0] : 1'b0, ex[k], m, 1'b0);

    // R8 rejected operands
    check_err(1'b0, 1'b0, 3, 0);
    check_err(1'b1, 1'b0, -2, 8'h7F);
    check_err(1'b1, 1'b1, 2, 8'hA0);
    check_err(1'b0, 1'b1, 0, 8'h00);
    // recovery after an error
    check_valid(1'b1, 1'b0, -5, 8'hB7, 1'b0);

    // R11 start ignored while busy
    check_valid(1'b0, 1'b1, 9, 8'h95, 1'b1);
    check_valid(1'b1, 1'b0, -11, 8'hE1, 1'b1);

    // R10 pulse and hold
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    hold_man = res_man; hold_exp = res_exp;
    repeat (4) @(negedge clk);
    chk(res_man == hold_man && res_exp == hold_exp, "R10 result held", res_man, hold_man);
    chk(busy == 1'b0, "R9 idle after done", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule